// File: doc/BRIEF.md
# Remote DMA Data Port with Ring Wrap

This block is the host-facing remote DMA engine of a legacy Ethernet controller. A host loads a transfer address, a byte count and a pair of ring page bounds through a small register write port. It then moves data to or from the on-board packet buffer by repeated accesses on a data port. Each access moves one, two or four bytes, advances the transfer address and counts the transfer down. When the count runs out, the block raises a completion status bit that can drive an interrupt.

The packet buffer sits inside the block as a byte array. It covers two mapped regions: a small low region starting at address zero, and a packet window from `WIN_START` up to `MEM_BYTES`. Bytes between the two regions, and bytes above the window, are unmapped. Writes to them are lost and reads from them return all ones. Multi-byte values use little-endian order. When an access leaves the address exactly on the ring stop boundary, the address is reloaded with the ring start boundary.

Top module: `rdma_port`

## Requirements
- R1: After reset the transfer address, transfer count, status byte, read data and interrupt output are all zero.
- R2: A narrow data port access moves 1 byte when configuration bit 0 (register select 4, write data bit 0) is 0, and 2 bytes when it is 1. A wide access (`dp_wide_i`=1) always moves 4 bytes. After each performed access the address advances by that byte count.
- R3: Ring start and stop are page numbers written at selects 2 and 3 from write data bits 7:0; the byte boundary is page times 256. If the advanced address equals the stop boundary exactly, it is reloaded with the start boundary. An address that steps past the stop boundary without equalling it is kept.
- R4: If the count is less than or equal to the access size, the count becomes zero and status bit 6 is set. Otherwise the count drops by the access size.
- R5: A data port write while the count is zero changes nothing: buffer contents, address and count stay the same. A read at zero count is still performed, advances the address, and sets status bit 6 again.
- R6: 2- and 4-byte accesses force address bit 0 to zero when touching the buffer and keep bit 1. 1-byte accesses use the address unchanged.
- R7: A byte is mapped when its address is below 32 or lies from `WIN_START` up to `MEM_BYTES`-1. Each byte lane is checked on its own: an unmapped lane drops its write data and reads as 0xFF.
- R8: The lowest addressed byte sits on data bits 7:0 and higher addresses sit in higher byte lanes. Lanes above the access size read as zero.
- R9: Writing at select 6 clears each status bit whose write data bit is 1. A completion event in the same cycle wins over the clear. Bits other than bit 6 never become set.
- R10: `irq_o` is high exactly when the bitwise AND of the status byte and the mask (select 5, write data bits 7:0) is nonzero.
- R11: Select 0 loads the 16-bit transfer address and select 1 loads the 16-bit transfer count. A register write to either one takes priority over a data port update of that register in the same cycle.
- R12: Read data is captured on the clock edge that performs a read access and holds until the next performed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (0 address, 1 count, 2 ring start page, 3 ring stop page, 4 config, 5 mask, 6 status clear) |
| reg_wdata_i | input | 16 | Register write data |
| dp_valid_i | input | 1 | Data port access strobe, one access per cycle |
| dp_write_i | input | 1 | 1 for a write access, 0 for a read access |
| dp_wide_i | input | 1 | Selects the 4-byte path |
| dp_wdata_i | input | 32 | Data port write data, little-endian |
| dp_rdata_o | output | 32 | Data port read data, registered |
| raddr_o | output | 16 | Current transfer address |
| rcnt_o | output | 16 | Remaining transfer count |
| isr_o | output | 8 | Status byte, completion on bit 6 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a multi-byte access that straddles a mapping edge or the ring stop boundary, with the count also running out on that same access. In that case the address wrap, lane masking and count saturation all act in one cycle. The stimulus first fills every mapped byte through the data port. It then runs directed accesses placed at the window edges, the low region edge and the stop boundary. After that it runs seeded random accesses with small counts and addresses spread across both sides of each edge, so that wide accesses often overrun the count, cross a region edge, or step past the stop boundary without landing on it.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR   = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_PSTART = 3'd2,
    SEL_PSTOP  = 3'd3,
    SEL_CFG    = 3'd4,
    SEL_MASK   = 3'd5,
    SEL_STATUS = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam int DONE_BIT = 6;
  localparam int LANES    = 4;

  function automatic logic [2:0] access_bytes(logic wide, logic half);
    if (wide)      return 3'd4;
    else if (half) return 3'd2;
    else           return 3'd1;
  endfunction
endpackage

// File: rtl/rdma_step.sv
module rdma_step #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] stop_i,
  input  logic [2:0]    nbytes_i,
  output logic [AW-1:0] addr_nxt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          done_o
);
  logic [AW-1:0] sum;

  always_comb begin
    sum        = addr_i + AW'(nbytes_i);
    // only exact equality reloads
    addr_nxt_o = (sum == stop_i) ? start_i : sum;
    done_o     = (cnt_i <= CW'(nbytes_i));
    cnt_nxt_o  = done_o ? '0 : (cnt_i - CW'(nbytes_i));
  end
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf import rdma_pkg::*; #(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_START = 'h400,
  parameter int MEM_BYTES = 'h800
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        base_i,
  input  logic [2:0]           nbytes_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output logic [8*LANES-1:0]   rdata_o
);
  localparam int WIN_BYTES = MEM_BYTES - WIN_START;
  localparam int STORE     = LOW_BYTES + WIN_BYTES;
  localparam int IW        = $clog2(STORE);

  logic [7:0] mem [STORE];

  logic [AW-1:0] lane_addr [LANES];
  logic [IW-1:0] lane_idx  [LANES];
  logic [LANES-1:0] lane_ok;
  logic [LANES-1:0] lane_on;

  function automatic logic is_mapped(logic [AW-1:0] a);
    return (int'(a) < LOW_BYTES) || (int'(a) >= WIN_START && int'(a) < MEM_BYTES);
  endfunction

  function automatic logic [IW-1:0] to_idx(logic [AW-1:0] a);
    if (int'(a) < LOW_BYTES) return IW'(a);
    else                     return IW'(int'(a) - WIN_START + LOW_BYTES);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = base_i + AW'(g);
    assign lane_ok[g]   = is_mapped(lane_addr[g]);
    assign lane_idx[g]  = to_idx(lane_addr[g]);
    assign lane_on[g]   = (3'(g) < nbytes_i);
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i && lane_on[l] && lane_ok[l]) mem[lane_idx[l]] <= wdata_i[8*l +: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_on[l]) rdata_o[8*l +: 8] = lane_ok[l] ? mem[lane_idx[l]] : 8'hFF;
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl import rdma_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  reg_sel_e      reg_sel_i,
  input  logic [RW-1:0] reg_wdata_i,
  input  logic          dp_valid_i,
  input  logic          dp_write_i,
  input  logic [2:0]    nbytes_i,
  output logic          go_o,
  output logic          half_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic [7:0]    imr_o,
  output logic [7:0]    isr_o
);
  localparam int PW = AW - 8;

  logic [AW-1:0] addr_q, addr_nxt, start_b, stop_b;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [PW-1:0] pstart_q, pstop_q;
  logic          half_q, done;
  logic [7:0]    imr_q, isr_q, clr_mask, set_mask;
  logic          wr_addr, wr_cnt;

  assign start_b  = {pstart_q, 8'h00};
  assign stop_b   = {pstop_q, 8'h00};
  // writes need a nonzero count, reads always proceed
  assign go_o     = dp_valid_i && (!dp_write_i || (cnt_q != '0));
  assign wr_addr  = reg_we_i && (reg_sel_i == SEL_ADDR);
  assign wr_cnt   = reg_we_i && (reg_sel_i == SEL_COUNT);
  assign clr_mask = (reg_we_i && reg_sel_i == SEL_STATUS) ? reg_wdata_i[7:0] : 8'h00;
  assign set_mask = (go_o && done) ? (8'h01 << DONE_BIT) : 8'h00;

  rdma_step #(.AW(AW), .CW(CW)) u_step (
    .addr_i     (addr_q),
    .cnt_i      (cnt_q),
    .start_i    (start_b),
    .stop_i     (stop_b),
    .nbytes_i   (nbytes_i),
    .addr_nxt_o (addr_nxt),
    .cnt_nxt_o  (cnt_nxt),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      pstart_q <= '0;
      pstop_q  <= '0;
      half_q   <= 1'b0;
      imr_q    <= '0;
      isr_q    <= '0;
    end else begin
      if (wr_addr)   addr_q <= AW'(reg_wdata_i);
      else if (go_o) addr_q <= addr_nxt;
      if (wr_cnt)    cnt_q  <= CW'(reg_wdata_i);
      else if (go_o) cnt_q  <= cnt_nxt;
      if (reg_we_i && reg_sel_i == SEL_PSTART) pstart_q <= reg_wdata_i[PW-1:0];
      if (reg_we_i && reg_sel_i == SEL_PSTOP)  pstop_q  <= reg_wdata_i[PW-1:0];
      if (reg_we_i && reg_sel_i == SEL_CFG)    half_q   <= reg_wdata_i[0];
      if (reg_we_i && reg_sel_i == SEL_MASK)   imr_q    <= reg_wdata_i[7:0];
      isr_q <= (isr_q & ~clr_mask) | set_mask;
    end
  end

  assign half_o = half_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign imr_o  = imr_q;
  assign isr_o  = isr_q;

  // R5
  zero_cnt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_valid_i && dp_write_i && cnt_q == '0 && !reg_we_i) |=> ($stable(addr_q) && cnt_q == '0));

  // R4
  done_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && cnt_q <= CW'(nbytes_i) && !reg_we_i) |=> (isr_q[DONE_BIT] && cnt_q == '0));

  // R3
  never_rest_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !reg_we_i && start_b != stop_b) |=> (addr_q != stop_b));

  // R4
  cnt_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/rdma_port.sv
module rdma_port import rdma_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_START = 'h400,
  parameter int MEM_BYTES = 'h800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              dp_valid_i,
  input  logic              dp_write_i,
  input  logic              dp_wide_i,
  input  logic [31:0]       dp_wdata_i,
  output logic [31:0]       dp_rdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [CNT_W-1:0]  rcnt_o,
  output logic [7:0]        isr_o,
  output logic              irq_o
);
  logic              go, half;
  logic [2:0]        nbytes;
  logic [ADDR_W-1:0] addr, base;
  logic [7:0]        imr, isr;
  logic [31:0]       buf_rdata, rdata_q;

  assign nbytes = access_bytes(dp_wide_i, half);
  // multi-byte accesses drop address bit 0 only
  assign base   = (nbytes != 3'd1) ? {addr[ADDR_W-1:1], 1'b0} : addr;

  rdma_ctrl #(.AW(ADDR_W), .CW(CNT_W), .RW(16)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_e'(reg_sel_i)),
    .reg_wdata_i (reg_wdata_i),
    .dp_valid_i  (dp_valid_i),
    .dp_write_i  (dp_write_i),
    .nbytes_i    (nbytes),
    .go_o        (go),
    .half_o      (half),
    .addr_o      (addr),
    .cnt_o       (rcnt_o),
    .imr_o       (imr),
    .isr_o       (isr)
  );

  rdma_buf #(
    .AW(ADDR_W), .LOW_BYTES(LOW_BYTES), .WIN_START(WIN_START), .MEM_BYTES(MEM_BYTES)
  ) u_buf (
    .clk_i    (clk_i),
    .we_i     (go && dp_write_i),
    .base_i   (base),
    .nbytes_i (nbytes),
    .wdata_i  (dp_wdata_i),
    .rdata_o  (buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= '0;
    else if (go && !dp_write_i)  rdata_q <= buf_rdata;
  end

  assign dp_rdata_o = rdata_q;
  assign raddr_o    = addr;
  assign isr_o      = isr;
  assign irq_o      = |(isr & imr);

  // R10
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (isr_o != 8'h00));

  // R9
  only_done_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o & ~(8'h01 << DONE_BIT)) == 8'h00);

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_valid_i && !dp_write_i) |=> $stable(dp_rdata_o));
endmodule

// File: tb/rdma_port_tb.sv
module rdma_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_START  = 'h400;
  localparam int MEM_BYTES  = 'h800;
  localparam int LOW_BYTES  = 32;

  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic        dp_valid, dp_write, dp_wide;
  logic [31:0] dp_wdata, dp_rdata;
  logic [15:0] raddr, rcnt;
  logic [7:0]  isr;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [7:0]  ref_mem [MEM_BYTES];
  logic [15:0] m_addr, m_cnt, m_start, m_stop;
  logic        m_half;
  logic [7:0]  m_imr, m_isr;
  logic [31:0] m_rdata;

  rdma_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .dp_valid_i(dp_valid), .dp_write_i(dp_write),
    .dp_wide_i(dp_wide), .dp_wdata_i(dp_wdata), .dp_rdata_o(dp_rdata),
    .raddr_o(raddr), .rcnt_o(rcnt), .isr_o(isr), .irq_o(irq)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(int a);
    return (a < LOW_BYTES) || (a >= WIN_START && a < MEM_BYTES);
  endfunction

  task automatic check_state(string req);
    chk(req, "address", {16'h0, raddr}, {16'h0, m_addr});
    chk(req, "count", {16'h0, rcnt}, {16'h0, m_cnt});
    chk(req, "status", {24'h0, isr}, {24'h0, m_isr});
    chk("R10", "irq", {31'h0, irq}, {31'h0, |(m_isr & m_imr)});
  endtask

  task automatic reg_wr(logic [2:0] sel, logic [15:0] data);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 0;
    case (sel)
      3'd0: m_addr  = data;
      3'd1: m_cnt   = data;
      3'd2: m_start = {data[7:0], 8'h00};
      3'd3: m_stop  = {data[7:0], 8'h00};
      3'd4: m_half  = data[0];
      3'd5: m_imr   = data[7:0];
      3'd6: m_isr   = m_isr & ~data[7:0];
      default: ;
    endcase
  endtask

  // one data port access, model update, then compare
  task automatic dp(bit wr, bit wide, logic [31:0] wd, string req);
    int n;
    logic [15:0] base, a, sum;
    logic [31:0] v;
    @(negedge clk);
    dp_valid = 1; dp_write = wr; dp_wide = wide; dp_wdata = wd;
    @(negedge clk);
    dp_valid = 0;
    n = wide ? 4 : (m_half ? 2 : 1);
    if (!(wr && m_cnt == 0)) begin
      base = (n > 1) ? (m_addr & 16'hFFFE) : m_addr;
      v = 0;
      for (int i = 0; i < n; i++) begin
        a = base + 16'(i);
        if (wr) begin
          if (mapped(int'(a))) ref_mem[a[10:0]] = wd[8*i +: 8];
        end else begin
          v[8*i +: 8] = mapped(int'(a)) ? ref_mem[a[10:0]] : 8'hFF;
        end
      end
      if (!wr) m_rdata = v;
      sum = m_addr + 16'(n);
      m_addr = (sum == m_stop) ? m_start : sum;
      if (int'(m_cnt) <= n) begin
        m_cnt = 0;
        m_isr = m_isr | 8'h40;
      end else m_cnt = m_cnt - 16'(n);
    end
    check_state(req);
    if (!wr) chk(req, "rdata", dp_rdata, m_rdata);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    dp_valid = 0; dp_write = 0; dp_wide = 0; dp_wdata = 0;
    m_addr = 0; m_cnt = 0; m_start = 0; m_stop = 0; m_half = 0;
    m_imr = 0; m_isr = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "address", {16'h0, raddr}, 32'h0);
    chk("R1", "count", {16'h0, rcnt}, 32'h0);
    chk("R1", "status", {24'h0, isr}, 32'h0);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
    chk("R1", "rdata", dp_rdata, 32'h0);

    // fill all mapped bytes with wide writes (R2 R11)
    reg_wr(3'd2, 16'h0004);
    reg_wr(3'd3, 16'h0008);
    reg_wr(3'd0, 16'h0000);
    reg_wr(3'd1, 16'd32);
    for (int i = 0; i < 8; i++) dp(1, 1, $urandom, "R2");
    reg_wr(3'd0, 16'h0400);
    reg_wr(3'd1, 16'd1024);
    for (int i = 0; i < 256; i++) dp(1, 1, $urandom, "R2");
    chk("R3", "wrap after fill", {16'h0, raddr}, 32'h400);
    reg_wr(3'd6, 16'h00FF);
    chk("R9", "status cleared", {24'h0, isr}, 32'h0);

    // R3 exact stop reload with 8-bit access
    reg_wr(3'd3, 16'h0006);
    reg_wr(3'd4, 16'h0000);
    reg_wr(3'd0, 16'h05FF);
    reg_wr(3'd1, 16'd5);
    dp(1, 0, 32'h0000_00A5, "R3");
    chk("R3", "reload to start", {16'h0, raddr}, 32'h400);

    // R6 odd address 16-bit: bit 0 dropped
    reg_wr(3'd4, 16'h0001);
    reg_wr(3'd0, 16'h0403);
    dp(1, 0, 32'h0000_BEEF, "R6");
    chk("R6", "advance from odd", {16'h0, raddr}, 32'h405);
    reg_wr(3'd0, 16'h0402);
    dp(0, 0, 0, "R8");
    chk("R8", "halfword little-endian", dp_rdata, 32'h0000_BEEF);
    reg_wr(3'd4, 16'h0000);
    reg_wr(3'd0, 16'h0402);
    dp(0, 0, 0, "R8");
    chk("R8", "low byte first", dp_rdata, 32'h0000_00EF);

    // R3 step past stop without equality
    reg_wr(3'd0, 16'h05FE);
    reg_wr(3'd1, 16'd40);
    dp(1, 1, 32'h1122_3344, "R3");
    chk("R3", "no reload past stop", {16'h0, raddr}, 32'h602);

    // R4 oversized final access, interrupt via mask
    reg_wr(3'd5, 16'h0040);
    reg_wr(3'd0, 16'h0410);
    reg_wr(3'd1, 16'd3);
    dp(1, 1, 32'hCAFE_F00D, "R4");
    chk("R4", "count saturates", {16'h0, rcnt}, 32'h0);
    chk("R10", "irq raised", {31'h0, irq}, 32'h1);

    // R5 write with zero count ignored, then read back the same spot
    dp(1, 1, 32'h0BAD_0BAD, "R5");
    chk("R5", "address held", {16'h0, raddr}, 32'h414);
    reg_wr(3'd6, 16'h0040);
    chk("R10", "irq dropped", {31'h0, irq}, 32'h0);
    reg_wr(3'd0, 16'h0414);
    dp(0, 1, 0, "R5");
    chk("R5", "read at zero count sets status", {24'h0, isr}, 32'h40);
    reg_wr(3'd1, 16'd8);
    reg_wr(3'd0, 16'h0410);
    dp(0, 1, 0, "R8");
    chk("R8", "word little-endian", dp_rdata, 32'hCAFE_F00D);

    // R7 unmapped gap and lane straddle
    reg_wr(3'd0, 16'h0100);
    reg_wr(3'd1, 16'd8);
    dp(1, 1, 32'h1234_5678, "R7");
    reg_wr(3'd0, 16'h0100);
    dp(0, 1, 0, "R7");
    chk("R7", "gap reads ones", dp_rdata, 32'hFFFF_FFFF);
    reg_wr(3'd0, 16'h001E);
    dp(0, 1, 0, "R7");
    chk("R7", "upper lanes past low region", dp_rdata[31:16], 32'h0000_FFFF);
    reg_wr(3'd0, 16'h03FE);
    dp(0, 1, 0, "R7");
    chk("R7", "lower lanes below window", dp_rdata[15:0], 32'h0000_FFFF);

    // R12 read data holds across writes
    dp(1, 0, 32'h77, "R12");
    chk("R12", "rdata held", dp_rdata, m_rdata);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      if ($urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 6))
          0: reg_wr(3'd0, 16'($urandom_range(0, 'h900)));
          1: reg_wr(3'd1, 16'($urandom_range(0, 12)));
          2: reg_wr(3'd2, 16'($urandom_range(4, 6)));
          3: reg_wr(3'd3, 16'($urandom_range(5, 8)));
          4: reg_wr(3'd4, 16'($urandom_range(0, 1)));
          5: reg_wr(3'd5, 16'($urandom_range(0, 255)));
          default: reg_wr(3'd6, 16'($urandom_range(0, 255)));
        endcase
      end
      dp(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom, "R4");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule